// File: doc/BRIEF.md
# Modbus RTU Request Frame Receiver

This block sits between a byte-level UART receiver (9600 baud, 8 data bits) and a request handler. It turns a loose stream of received bytes into whole Modbus RTU request frames. Frame edges are found only by silence on the line: a gap of 28 bit times (3.5 characters counted without framing bits) closes the frame in progress. The first byte of each frame is compared against the configured unit address. Frames for other units are thrown away, as are frames that overflow the buffer, frames that are too short and frames whose CRC-16 does not check. A frame that passes is held in an internal buffer and offered to the handler.

The byte input is a plain strobe with no back-pressure, because a UART cannot be stalled. Bytes that arrive while the transmitter reports busy, or while a finished frame waits to be taken, are dropped. The frame output follows valid/ready rules. Once `frame_valid` rises, it stays high, and `frame_len` and the buffer contents stay fixed, until the cycle in which `frame_ready` is sampled high. `frame_valid` falls on the next edge. While `frame_valid` is high, the handler reads any byte through `rd_addr`/`rd_data`, which is a combinational read.

Top module: `mbus_frame_rx`

## Requirements
- R1: While reset is asserted and right after it, `frame_valid` is 0 and `frame_len` is 0.
- R2: A frame whose first byte equals `unit_id`, with at least 4 bytes, at most DEPTH bytes and a correct CRC, is offered with `frame_len` equal to its full byte count including both CRC bytes. Buffer address i returns the i-th received byte, counting from 0.
- R3: `frame_valid` stays high with a stable `frame_len` until `frame_ready` is sampled high, and falls on the following edge. Bytes received while it is high are discarded and never form a frame.
- R4: The gap threshold GAP is 28*CLK_HZ/BAUD cycles. A byte strobed GAP cycles after the previous accepted strobe continues the frame. A byte strobed GAP+1 or more cycles later starts a new frame. `frame_valid` rises GAP+1 edges after the edge that sampled the last byte.
- R5: When the first byte of a frame differs from `unit_id`, the whole frame is discarded.
- R6: Frames of fewer than 4 bytes are discarded silently, even if their CRC is correct. A 4-byte frame is accepted.
- R7: The CRC uses seed 0xFFFF and the reflected polynomial 0xA001, and is shifted right one bit at a time, LSB first. It covers every byte except the last two. The final two bytes hold the CRC, low byte first and then high byte. Any mismatch, including swapped CRC bytes, discards the frame.
- R8: A frame of exactly DEPTH bytes is accepted. A frame whose byte DEPTH+1 arrives is discarded as a whole.
- R9: Bytes strobed while `tx_busy` is 1 are ignored. They neither join nor restart a frame, and they do not reset the gap timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| unit_id | input | 8 | Configured slave address |
| tx_busy | input | 1 | Reply transmitter active; incoming bytes are ignored |
| frame_valid | output | 1 | A checked frame is available |
| frame_ready | input | 1 | Handler takes the frame and frees the buffer |
| frame_len | output | $clog2(DEPTH+1) | Byte count of the offered frame, including the CRC; 0 when none |
| rd_addr | input | $clog2(DEPTH) | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_addr` |

## Verification
The receiver is driven with good frames at two byte spacings and with a frame whose bytes are spaced exactly at the gap threshold. These runs separate correct gap counting from an off-by-one that would split or merge frames. A short fragment followed by a gap of one cycle more than the threshold shows that a new frame starts on that edge. Foreign-address, 3-byte, corrupted-CRC, swapped-CRC and one-byte-too-long frames must all vanish. The 4-byte and DEPTH-byte frames show where each length limit sits. Bytes injected during transmitter activity and during a pending hand-over show whether those bytes leak into the buffer or the timer.

// File: rtl/mbus_rx_pkg.sv
package mbus_rx_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_HOLD    = 1'b1
  } rx_state_e;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'hA001;

  // One byte through the reflected CRC-16, LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                             input logic [7:0]  d);
    logic [15:0] c;
    c = c_in ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/mbus_gap_timer.sv
module mbus_gap_timer #(
  parameter int unsigned LIMIT = 280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  // Saturating cycles-since-last-byte; starts idle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= CW'(LIMIT);
    else if (clr)               cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/mbus_crc16.sv
module mbus_crc16
  import mbus_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [7:0] data,
  output logic       zero
);
  logic [15:0] crc;
  logic [15:0] base;

  assign base = restart ? CRC_SEED : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc <= CRC_SEED;
    else if (en) crc <= crc16_step(base, data);
  end

  // Running over message plus appended CRC leaves a zero residue.
  assign zero = (crc == 16'h0000);
endmodule

// File: rtl/mbus_frame_buf.sv
module mbus_frame_buf #(
  parameter int DEPTH = 180,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/mbus_frame_rx.sv
module mbus_frame_rx
  import mbus_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned BAUD    = 9600,
  parameter int          DEPTH   = 180,
  parameter int          MIN_LEN = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [7:0]    unit_id,
  input  logic          tx_busy,
  output logic          frame_valid,
  input  logic          frame_ready,
  output logic [LW-1:0] frame_len,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int unsigned GAP_CYC = int'((64'd28 * 64'(CLK_HZ)) / 64'(BAUD));

  rx_state_e     state;
  logic [LW-1:0] len;
  logic          drop;
  logic          expired, crc_zero;
  logic          collecting, accept, active, close, good, handoff;
  logic          start, cont, store, overflow;
  logic [AW-1:0] wr_addr;

  always_comb begin
    collecting = (state == ST_COLLECT);
    accept     = rx_valid && !tx_busy && collecting;
    active     = (len != '0);
    close      = collecting && expired && active;
    good       = !drop && (len >= LW'(MIN_LEN)) && crc_zero;
    handoff    = close && good;
    start      = accept && !handoff && (expired || !active);
    cont       = accept && active && !expired;
    store      = (start && (rx_data == unit_id)) ||
                 (cont && !drop && (len != LW'(DEPTH)));
    overflow   = cont && !drop && (len == LW'(DEPTH));
    wr_addr    = start ? '0 : AW'(len);
  end

  mbus_gap_timer #(.LIMIT(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .expired (expired)
  );

  mbus_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (store),
    .restart (start),
    .data    (rx_data),
    .zero    (crc_zero)
  );

  mbus_frame_buf #(.DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (store),
    .waddr (wr_addr),
    .wdata (rx_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      len   <= '0;
      drop  <= 1'b0;
    end else begin
      unique case (state)
        ST_COLLECT: begin
          if (handoff) begin
            state <= ST_HOLD;
          end else if (start) begin
            len  <= LW'(1);
            drop <= (rx_data != unit_id);
          end else if (close) begin
            len  <= '0;
            drop <= 1'b0;
          end else if (store) begin
            len <= len + 1'b1;
          end else if (overflow) begin
            drop <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (frame_ready) begin
            state <= ST_COLLECT;
            len   <= '0;
            drop  <= 1'b0;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  assign frame_valid = (state == ST_HOLD);
  assign frame_len   = frame_valid ? len : '0;
endmodule

// File: rtl/mbus_frame_rx_chk.sv
module mbus_frame_rx_chk #(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned BAUD    = 9600,
  parameter int          DEPTH   = 180,
  parameter int          MIN_LEN = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          tx_busy,
  input logic          frame_valid,
  input logic          frame_ready,
  input logic [LW-1:0] frame_len
);
  localparam int unsigned GAP  = int'((64'd28 * 64'(CLK_HZ)) / 64'(BAUD));
  localparam int unsigned QMAX = GAP + 3;
  localparam int          QW   = $clog2(QMAX + 1);

  // Edges since the last strobe that the port rules let in.
  logic [QW-1:0] quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            quiet <= QW'(QMAX);
    else if (rx_valid && !tx_busy && !frame_valid) quiet <= QW'(1);
    else if (quiet != QW'(QMAX))           quiet <= quiet + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !frame_valid);

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !frame_ready |=> frame_valid && $stable(frame_len));

  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_ready |=> !frame_valid);

  // R4: the close edge sits GAP+1 edges after the last byte; a byte landing
  // on the hand-over edge itself is dropped and only restarts this counter.
  a_r4_gap_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> (quiet == QW'(GAP + 2)) || (quiet == QW'(1)));

  a_r6_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len >= LW'(MIN_LEN)) && (frame_len <= LW'(DEPTH)));
endmodule

bind mbus_frame_rx mbus_frame_rx_chk #(
  .CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH), .MIN_LEN(MIN_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_busy(tx_busy),
  .frame_valid(frame_valid), .frame_ready(frame_ready), .frame_len(frame_len)
);

// File: tb/test_mbus_frame_rx.sv
`timescale 1ns/1ps
module test_mbus_frame_rx;
  localparam int unsigned CLK_HZ = 96000;
  localparam int unsigned BAUD   = 9600;
  localparam int DEPTH = 20;
  localparam int GAP   = 280;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);
  localparam logic [7:0] ID = 8'h11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, rx_valid, tx_busy, frame_valid, frame_ready;
  logic [7:0]    rx_data, unit_id, rd_data;
  logic [LW-1:0] frame_len;
  logic [AW-1:0] rd_addr;

  int n_chk = 0, n_bad = 0, mon_delay = 0;
  bit finished = 0;
  logic [7:0] fr[$];
  int         exp_len[$];
  logic [7:0] exp_byte[$];

  mbus_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH)) i_mbus_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .unit_id(unit_id), .tx_busy(tx_busy), .frame_valid(frame_valid),
    .frame_ready(frame_ready), .frame_len(frame_len), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fr[i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  task automatic seal();
    logic [15:0] c = ref_crc(fr.size());
    fr.push_back(c[7:0]);
    fr.push_back(c[15:8]);
  endtask

  task automatic put(input logic [7:0] b, input int idle);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  // Scoreboard driver: queue the frame if it should come out, then send it.
  task automatic send_fr(input bit expect_ok, input int idle);
    if (expect_ok) begin
      exp_len.push_back(fr.size());
      foreach (fr[i]) exp_byte.push_back(fr[i]);
    end
    for (int i = 0; i < fr.size(); i++) put(fr[i], (i == fr.size() - 1) ? 0 : idle);
  endtask

  task automatic settle();
    repeat (GAP + 40) @(negedge clk);
  endtask

  task automatic expect_none(input string req);
    settle();
    check(!frame_valid && exp_len.size() == 0, req, exp_len.size(), 0);
  endtask

  // Monitor: pop and compare each offered frame, then accept it.
  initial begin
    int n;
    logic [7:0] e;
    frame_ready = 1'b0;
    rd_addr = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && frame_valid) begin
        repeat (mon_delay) @(negedge clk);
        if (exp_len.size() == 0) begin
          check(1'b0, "R5/R6/R7/R8/R9 dropped frame delivered", int'(frame_len), 0);
        end else begin
          n = exp_len.pop_front();
          check(int'(frame_len) == n, "R2 frame length", int'(frame_len), n);
          for (int i = 0; i < n; i++) begin
            e = exp_byte.pop_front();
            rd_addr = AW'(i);
            #1;
            check(rd_data == e, "R2 buffer byte", rd_data, e);
          end
        end
        @(negedge clk); frame_ready = 1'b1;
        @(negedge clk); frame_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] t;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; unit_id = ID; tx_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(!frame_valid && frame_len == '0, "R1 reset state", frame_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!frame_valid, "R1 after reset", frame_valid, 0);

    // R2/R4: read request, exact close timing
    fr = {ID, 8'h03, 8'h00, 8'h10, 8'h00, 8'h02}; seal();
    send_fr(1, 8);
    repeat (GAP) @(negedge clk);
    check(!frame_valid, "R4 still receiving at GAP", frame_valid, 0);
    @(negedge clk);
    check(frame_valid, "R4 closed at GAP+1", frame_valid, 1);
    settle();

    // R2: write request, tighter spacing
    fr = {ID, 8'h06, 8'h00, 8'h01, 8'h00, 8'hDC}; seal();
    send_fr(1, 3);
    settle();

    // R4: spacing exactly GAP keeps one frame
    fr = {ID, 8'h03, 8'h00, 8'h00, 8'h00, 8'h01}; seal();
    send_fr(1, GAP - 2);
    settle();
    check(exp_len.size() == 0, "R4 GAP spacing is one frame", exp_len.size(), 0);

    // R4/R6: fragment, gap GAP+1, then a good frame
    fr = {ID, 8'h03}; send_fr(0, 8);
    repeat (GAP - 1) @(negedge clk);
    fr = {ID, 8'h04, 8'h00, 8'h02, 8'h00, 8'h01}; seal();
    send_fr(1, 8);
    settle();
    check(exp_len.size() == 0, "R4 restart after GAP+1", exp_len.size(), 0);

    // R5: foreign unit
    fr = {8'h22, 8'h03, 8'h00, 8'h10, 8'h00, 8'h02}; seal();
    send_fr(0, 8);
    expect_none("R5 foreign unit dropped");

    // R6: 3 bytes with good CRC dropped, 4 bytes accepted
    fr = {ID}; seal(); send_fr(0, 8);
    expect_none("R6 short frame dropped");
    fr = {ID, 8'h07}; seal(); send_fr(1, 8);
    settle();
    check(exp_len.size() == 0, "R6 four-byte frame", exp_len.size(), 0);

    // R7: corrupted and swapped CRC
    fr = {ID, 8'h03, 8'h00, 8'h10, 8'h00, 8'h02}; seal();
    fr[fr.size() - 1] = fr[fr.size() - 1] ^ 8'h01;
    send_fr(0, 8);
    expect_none("R7 bad CRC dropped");
    fr = {ID, 8'h03, 8'h00, 8'h10, 8'h00, 8'h02}; seal();
    t = fr[fr.size() - 1]; fr[fr.size() - 1] = fr[fr.size() - 2]; fr[fr.size() - 2] = t;
    send_fr(0, 8);
    expect_none("R7 swapped CRC dropped");

    // R8: full buffer accepted, one more byte drops it
    fr = {ID}; for (int i = 0; i < DEPTH - 3; i++) fr.push_back(8'(i * 7 + 1)); seal();
    send_fr(1, 4);
    settle();
    check(exp_len.size() == 0, "R8 DEPTH-byte frame", exp_len.size(), 0);
    fr = {ID}; for (int i = 0; i < DEPTH - 2; i++) fr.push_back(8'(i + 9)); seal();
    send_fr(0, 4);
    expect_none("R8 overrun dropped");

    // R9: bytes while busy are ignored
    fr = {ID, 8'h03, 8'h00, 8'h10, 8'h00, 8'h02}; seal();
    tx_busy = 1'b1; send_fr(0, 8); tx_busy = 1'b0;
    expect_none("R9 busy frame ignored");
    fr = {ID, 8'h03, 8'h00, 8'h20, 8'h00, 8'h01}; seal();
    exp_len.push_back(fr.size());
    foreach (fr[i]) exp_byte.push_back(fr[i]);
    for (int i = 0; i < fr.size(); i++) begin
      if (i == 3) begin
        tx_busy = 1'b1; put(8'hAA, 8); tx_busy = 1'b0;
      end
      put(fr[i], (i == fr.size() - 1) ? 0 : 8);
    end
    settle();
    check(exp_len.size() == 0, "R9 busy byte not merged", exp_len.size(), 0);

    // R3: hold while pending, bytes meanwhile ignored
    mon_delay = 2 * GAP + 240;
    fr = {ID, 8'h03, 8'h00, 8'h05, 8'h00, 8'h01}; seal();
    send_fr(1, 8);
    repeat (GAP + 2) @(negedge clk);
    check(frame_valid, "R3 frame pending", frame_valid, 1);
    fr = {ID, 8'h06, 8'h00, 8'h02, 8'h00, 8'h09}; seal();
    send_fr(0, 8);
    repeat (GAP + 20) @(negedge clk);
    check(frame_valid, "R3 held without ready", frame_valid, 1);
    wait (frame_valid == 1'b0);
    mon_delay = 0;
    expect_none("R3 bytes during hold discarded");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule